// File: doc/BRIEF.md
# Indexed register write SPI framer

The framer takes a single register write, an 8-bit register index plus a 16-bit value, over a valid/ready handshake. It forwards that write to a display controller as two separate SPI transactions. The first transaction is the index phase. Chip select goes low, and the block shifts out a lead byte of 0x70, then a zero byte, then the index. Chip select then goes high for a short gap before the data phase starts. The data phase shifts out a lead byte of 0x72, then the upper and lower bytes of the value. When the data phase ends, the block pulses `done_o` for one cycle and is ready for the next write.

The serial side runs in SPI mode 0 and sends MSB first. SCLK idles low. MOSI changes only while SCLK is low, and the target samples it on the rising edge. The parameter `HALF_DIV` sets the length of each SCLK half period in system clock cycles. The same half period also sets the chip-select setup time before the first rising edge and the hold time after the last falling edge. The chip-select gap between the two phases lasts two half periods.

Top module: `spi_regwr_framer`

## Requirements
- R1: While reset is asserted, and directly after it, cs_n_o is high, sclk_o is low, req_ready_o is high and done_o is low.
- R2: A request is accepted on a rising clock edge where req_valid_i and req_ready_o are both high. req_ready_o is low from the next cycle up to the cycle in which done_o is high. It is high again in that done cycle.
- R3: The index transaction carries 24 bits, MSB first: the byte 0x70, then 0x00, then the accepted 8-bit index.
- R4: The data transaction carries 24 bits, MSB first: the byte 0x72, then value bits 15..8, then value bits 7..0.
- R5: Each write produces exactly two chip-select frames, the index frame first and then the data frame. Each frame has exactly 24 rising SCLK edges.
- R6: SCLK is low whenever cs_n_o is high. MOSI never changes while SCLK is high, so the receiver can sample it on the rising edge.
- R7: Every SCLK high and low phase lasts HALF_DIV clock cycles. The first rising edge comes HALF_DIV cycles after cs_n_o falls, and cs_n_o rises HALF_DIV cycles after the last falling edge.
- R8: Between the index frame and the data frame of one write, cs_n_o stays high for exactly 2*HALF_DIV cycles, which is one full SCLK period.
- R9: done_o is a one-cycle pulse in the first cycle that cs_n_o is high after the data frame. There is exactly one pulse per accepted write.
- R10: A request offered while a write is in progress is held off and not dropped. If req_valid_i is held, the request is accepted on the edge that ends the done cycle, so cs_n_o falls in the very next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| req_valid_i | input | 1 | Write request valid |
| req_ready_o | output | 1 | Framer idle and able to accept a request |
| req_idx_i | input | 8 | Register index of the request |
| req_val_i | input | 16 | Register value of the request |
| sclk_o | output | 1 | SPI clock, idles low |
| mosi_o | output | 1 | SPI serial data out |
| cs_n_o | output | 1 | SPI chip select, active low |
| done_o | output | 1 | One-cycle pulse when a write has fully completed |

## Verification
Two events can land in the same cycle: the done pulse that closes one write, and the acceptance of the next request, because ready returns high in that same cycle. The bench provokes this by issuing requests back to back with req_valid_i held high through the busy period, so the waiting request meets the done cycle head on. It then judges that chip select falls in the next cycle, with no idle bubble. It also checks that the held request's own index and data frames follow in order with the right bytes, so nothing was lost or duplicated.

// File: rtl/spi_regwr_pkg.sv
package spi_regwr_pkg;
  localparam int unsigned BYTE_W      = 8;
  localparam int unsigned IDX_W       = 8;
  localparam int unsigned VAL_W       = 16;
  localparam int unsigned FRAME_BYTES = 3;
  localparam int unsigned FRAME_W     = FRAME_BYTES * BYTE_W;
  localparam int unsigned BIT_CNT_W   = $clog2(FRAME_W);

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_SHIFT,
    ST_TAIL,
    ST_GAP
  } seq_state_e;

  typedef logic [FRAME_W-1:0] frame_t;

  function automatic frame_t idx_frame(input logic [BYTE_W-1:0] lead,
                                       input logic [IDX_W-1:0]  idx);
    return {lead, {BYTE_W{1'b0}}, idx};
  endfunction

  function automatic frame_t val_frame(input logic [BYTE_W-1:0] lead,
                                       input logic [VAL_W-1:0]  val);
    return {lead, val};
  endfunction
endpackage

// File: rtl/spi_regwr_tick.sv
module spi_regwr_tick #(
  parameter int unsigned HALF_DIV = 4
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic run_i,
  output logic tick_o
);
  localparam int unsigned CW = $clog2(HALF_DIV + 1);
  localparam logic [CW-1:0] LAST = CW'(HALF_DIV - 1);

  logic [CW-1:0] cnt_q;

  assign tick_o = run_i && (cnt_q == LAST);

  // counter restarts whenever the sequencer is idle, so phase 0 aligns to acceptance
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)               cnt_q <= '0;
    else if (!run_i || tick_o) cnt_q <= '0;
    else                       cnt_q <= cnt_q + 1'b1;
  end
endmodule

// File: rtl/spi_regwr_shifter.sv
module spi_regwr_shifter
  import spi_regwr_pkg::*;
(
  input  logic   clk_i,
  input  logic   rst_ni,
  input  logic   load_i,
  input  frame_t word_i,
  input  logic   shift_i,
  output logic   mosi_o
);
  frame_t sh_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      sh_q <= '0;
    else if (load_i)  sh_q <= word_i;
    else if (shift_i) sh_q <= {sh_q[FRAME_W-2:0], 1'b0};
  end

  assign mosi_o = sh_q[FRAME_W-1];
endmodule

// File: rtl/spi_regwr_seq.sv
module spi_regwr_seq
  import spi_regwr_pkg::*;
#(
  parameter logic [BYTE_W-1:0] IDX_LEAD = 8'h70,
  parameter logic [BYTE_W-1:0] DAT_LEAD = 8'h72
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             valid_i,
  input  logic [IDX_W-1:0] idx_i,
  input  logic [VAL_W-1:0] val_i,
  input  logic             tick_i,
  output logic             ready_o,
  output logic             run_o,
  output logic             load_o,
  output frame_t           word_o,
  output logic             shift_o,
  output logic             sclk_o,
  output logic             cs_n_o,
  output logic             done_o
);
  localparam logic [BIT_CNT_W-1:0] LAST_BIT = BIT_CNT_W'(FRAME_W - 1);

  seq_state_e           st_q, st_d;
  logic [BIT_CNT_W-1:0] bit_q, bit_d;
  logic [VAL_W-1:0]     val_q, val_d;
  logic                 sclk_q, sclk_d;
  logic                 cs_q, cs_d;
  logic                 done_q, done_d;
  logic                 dat_q, dat_d;
  logic                 gap_q, gap_d;

  assign ready_o = (st_q == ST_IDLE);
  assign run_o   = (st_q != ST_IDLE);
  assign word_o  = (st_q == ST_IDLE) ? idx_frame(IDX_LEAD, idx_i)
                                     : val_frame(DAT_LEAD, val_q);

  always_comb begin
    st_d    = st_q;
    bit_d   = bit_q;
    val_d   = val_q;
    sclk_d  = sclk_q;
    cs_d    = cs_q;
    done_d  = 1'b0;
    dat_d   = dat_q;
    gap_d   = gap_q;
    load_o  = 1'b0;
    shift_o = 1'b0;
    unique case (st_q)
      ST_IDLE: begin
        if (valid_i) begin
          load_o = 1'b1;
          val_d  = val_i;
          cs_d   = 1'b0;
          bit_d  = '0;
          dat_d  = 1'b0;
          st_d   = ST_SHIFT;
        end
      end
      ST_SHIFT: begin
        if (tick_i) begin
          if (!sclk_q) begin
            sclk_d = 1'b1;
          end else begin
            sclk_d = 1'b0;
            if (bit_q == LAST_BIT) begin
              st_d = ST_TAIL;
            end else begin
              bit_d   = bit_q + 1'b1;
              shift_o = 1'b1;
            end
          end
        end
      end
      ST_TAIL: begin
        if (tick_i) begin
          cs_d = 1'b1;
          if (dat_q) begin
            done_d = 1'b1;
            st_d   = ST_IDLE;
          end else begin
            gap_d = 1'b0;
            st_d  = ST_GAP;
          end
        end
      end
      ST_GAP: begin
        if (tick_i) begin
          if (gap_q) begin
            load_o = 1'b1;
            cs_d   = 1'b0;
            bit_d  = '0;
            dat_d  = 1'b1;
            st_d   = ST_SHIFT;
          end else begin
            gap_d = 1'b1;
          end
        end
      end
      default: st_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q   <= ST_IDLE;
      bit_q  <= '0;
      val_q  <= '0;
      sclk_q <= 1'b0;
      cs_q   <= 1'b1;
      done_q <= 1'b0;
      dat_q  <= 1'b0;
      gap_q  <= 1'b0;
    end else begin
      st_q   <= st_d;
      bit_q  <= bit_d;
      val_q  <= val_d;
      sclk_q <= sclk_d;
      cs_q   <= cs_d;
      done_q <= done_d;
      dat_q  <= dat_d;
      gap_q  <= gap_d;
    end
  end

  assign sclk_o = sclk_q;
  assign cs_n_o = cs_q;
  assign done_o = done_q;
endmodule

// File: rtl/spi_regwr_framer.sv
module spi_regwr_framer
  import spi_regwr_pkg::*;
#(
  parameter int unsigned       HALF_DIV = 4,
  parameter logic [BYTE_W-1:0] IDX_LEAD = 8'h70,
  parameter logic [BYTE_W-1:0] DAT_LEAD = 8'h72
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             req_valid_i,
  output logic             req_ready_o,
  input  logic [IDX_W-1:0] req_idx_i,
  input  logic [VAL_W-1:0] req_val_i,
  output logic             sclk_o,
  output logic             mosi_o,
  output logic             cs_n_o,
  output logic             done_o
);
  logic   run, tick, load, shift;
  frame_t word;

  spi_regwr_tick #(.HALF_DIV(HALF_DIV)) u_tick (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .run_i  (run),
    .tick_o (tick)
  );

  spi_regwr_seq #(.IDX_LEAD(IDX_LEAD), .DAT_LEAD(DAT_LEAD)) u_seq (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .valid_i (req_valid_i),
    .idx_i   (req_idx_i),
    .val_i   (req_val_i),
    .tick_i  (tick),
    .ready_o (req_ready_o),
    .run_o   (run),
    .load_o  (load),
    .word_o  (word),
    .shift_o (shift),
    .sclk_o  (sclk_o),
    .cs_n_o  (cs_n_o),
    .done_o  (done_o)
  );

  spi_regwr_shifter u_shift (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .load_i  (load),
    .word_i  (word),
    .shift_i (shift),
    .mosi_o  (mosi_o)
  );
endmodule

// File: rtl/spi_regwr_framer_chk.sv
module spi_regwr_framer_chk (
  input logic clk_i,
  input logic rst_ni,
  input logic req_valid_i,
  input logic req_ready_o,
  input logic sclk_o,
  input logic mosi_o,
  input logic cs_n_o,
  input logic done_o
);
  // R2
  accept_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_valid_i && req_ready_o |=> !req_ready_o && !cs_n_o);

  // R2
  busy_ready_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !cs_n_o |-> !req_ready_o);

  // R6
  idle_low_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cs_n_o |-> !sclk_o);

  // R6
  mosi_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sclk_o |-> $stable(mosi_o));

  // R7
  cs_fall_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(cs_n_o) |-> !sclk_o);

  // R9
  done_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);

  // R9
  done_cs_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> cs_n_o && req_ready_o);
endmodule

bind spi_regwr_framer spi_regwr_framer_chk u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .req_valid_i (req_valid_i),
  .req_ready_o (req_ready_o),
  .sclk_o      (sclk_o),
  .mosi_o      (mosi_o),
  .cs_n_o      (cs_n_o),
  .done_o      (done_o)
);

// File: tb/spi_regwr_framer_test.sv
module spi_regwr_framer_test;
  localparam int CLK_PERIOD = 10;
  localparam int HALF       = 4;
  localparam int SEED       = 1234;
  localparam int N_RAND     = 30;

  logic        clk   = 1'b0;
  logic        rst_n = 1'b0;
  logic        valid = 1'b0;
  logic [7:0]  idx   = '0;
  logic [15:0] val   = '0;
  logic        ready, sclk, mosi, cs_n, done;

  spi_regwr_framer #(.HALF_DIV(HALF)) uut (
    .clk_i       (clk),
    .rst_ni      (rst_n),
    .req_valid_i (valid),
    .req_ready_o (ready),
    .req_idx_i   (idx),
    .req_val_i   (val),
    .sclk_o      (sclk),
    .mosi_o      (mosi),
    .cs_n_o      (cs_n),
    .done_o      (done)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  int checks = 0, fails = 0;
  logic [7:0]  q_idx [256];
  logic [15:0] q_val [256];
  int n_sent = 0, n_frames = 0, n_done = 0;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  function automatic logic [23:0] exp_idx_frame(input logic [7:0] i);
    return {8'h70, 8'h00, i};
  endfunction

  function automatic logic [23:0] exp_val_frame(input logic [15:0] v);
    return {8'h72, v};
  endfunction

  // monitor: samples mid-cycle
  logic p_sclk = 1'b0, p_cs = 1'b1, p_mosi = 1'b0, p_done = 1'b0, p_valid = 1'b0, p_ready = 1'b1;
  int   since = 0, nbits = 0;
  logic [23:0] sh = '0;
  bit   busy = 1'b0;

  always @(negedge clk) begin
    if (rst_n) begin
      since++;
      if (p_valid && p_ready) busy = 1'b1;
      if (done) busy = 1'b0;
      chk(ready == !busy, "R2 ready level", int'(ready), int'(!busy));
      if (cs_n) chk(!sclk, "R6 sclk idle low", int'(sclk), 0);
      if (p_sclk && sclk) chk(mosi == p_mosi, "R6 mosi stable while sclk high", int'(mosi), int'(p_mosi));
      if (p_done && p_valid) chk(!cs_n, "R10 held request starts after done", int'(cs_n), 0);
      if (p_cs && !cs_n) begin
        if (n_frames % 2 == 1) chk(since == 2*HALF, "R8 cs gap", since, 2*HALF);
        nbits = 0;
        since = 0;
      end
      if (!p_sclk && sclk) begin
        chk(since == HALF, "R7 low phase", since, HALF);
        sh = {sh[22:0], mosi};
        nbits++;
        since = 0;
      end
      if (p_sclk && !sclk) begin
        chk(since == HALF, "R7 high phase", since, HALF);
        since = 0;
      end
      if (!p_cs && cs_n) begin
        chk(since == HALF, "R7 cs hold", since, HALF);
        chk(nbits == 24, "R5 bits per frame", nbits, 24);
        if (n_frames % 2 == 0)
          chk(sh == exp_idx_frame(q_idx[n_done]), "R3 index frame", int'(sh), int'(exp_idx_frame(q_idx[n_done])));
        else
          chk(sh == exp_val_frame(q_val[n_done]), "R4 data frame", int'(sh), int'(exp_val_frame(q_val[n_done])));
        n_frames++;
        since = 0;
      end
      if (done) begin
        chk(!p_done, "R9 single pulse", int'(p_done), 0);
        chk(!p_cs && cs_n && (n_frames % 2 == 0), "R9 done after data frame", n_frames, 2*(n_done+1));
        n_done++;
      end
      p_sclk  = sclk;
      p_cs    = cs_n;
      p_mosi  = mosi;
      p_done  = done;
      p_valid = valid;
      p_ready = ready;
    end
  end

  task automatic send(input logic [7:0] i, input logic [15:0] v);
    bit acc;
    valid = 1'b1;
    idx   = i;
    val   = v;
    forever begin
      acc = ready;
      @(posedge clk); #1;
      if (acc) break;
    end
    q_idx[n_sent] = i;
    q_val[n_sent] = v;
    n_sent++;
    valid = 1'b0;
    idx   = $urandom_range(0, 255);
    val   = $urandom_range(0, 65535);
  endtask

  task automatic wait_idle();
    while (!(ready && n_done == n_sent)) begin
      @(posedge clk); #1;
    end
  endtask

  initial begin
    void'($urandom(SEED));
    repeat (3) @(posedge clk);
    #1;
    chk(cs_n == 1'b1, "R1 reset cs", int'(cs_n), 1);
    chk(sclk == 1'b0, "R1 reset sclk", int'(sclk), 0);
    chk(ready == 1'b1, "R1 reset ready", int'(ready), 1);
    chk(done == 1'b0, "R1 reset done", int'(done), 0);
    rst_n = 1'b1;
    @(posedge clk); #1;
    chk(cs_n == 1'b1 && sclk == 1'b0 && ready == 1'b1, "R1 after reset idle", int'({cs_n, sclk, ready}), 5);
    // directed corners, back to back (R10)
    send(8'h00, 16'h0000);
    send(8'hFF, 16'hFFFF);
    send(8'hA5, 16'h5AC3);
    wait_idle();
    send(8'h01, 16'h8001);
    wait_idle();
    repeat (5) @(posedge clk);
    #1;
    for (int k = 0; k < N_RAND; k++) begin
      send(8'($urandom_range(0, 255)), 16'($urandom_range(0, 65535)));
      if ($urandom_range(0, 2) == 0) begin
        wait_idle();
        repeat ($urandom_range(0, 6)) @(posedge clk);
        #1;
      end
    end
    wait_idle();
    repeat (4) @(posedge clk);
    #1;
    chk(n_done == n_sent, "R9 one done per write", n_done, n_sent);
    chk(n_frames == 2*n_sent, "R5 two frames per write", n_frames, 2*n_sent);
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    checks++;
    fails++;
    $display("FAIL R9 watchdog: done count %0d expected %0d", n_done, n_sent);
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end
endmodule